// File: doc/BRIEF.md
# Microcontroller Internal Data Memory Unit

This block provides the 256-byte on-chip data space of an 8-bit microcontroller core. A single request port carries reads and writes of four kinds: a working-register access that goes through the current bank, a direct byte access, an indirect byte access, and a single-bit access. The block resolves each request to a byte location. That location is either its own 256-byte scratch RAM or an external special-function-register port, which has its own read and write strobes and returns data one cycle after a read strobe.

The upper half of the address map has two meanings. Indirect accesses there reach the upper 128 RAM bytes. Direct accesses there reach the register port. Bit accesses are remapped: the lower half of the bit space covers sixteen RAM bytes starting at 0x20, and the upper half covers the sixteen port registers whose addresses are multiples of eight. A bit write reads the containing byte, replaces one bit and writes the byte back. This costs one stall cycle. After reset the RAM is zeroed by a sequential sweep, and the block accepts no request until the sweep is finished.

Top module: `idm_unit`

## Requirements
- R1: After reset release, ready stays low for exactly 256 clock cycles while every RAM byte is cleared. A later indirect read of any address then returns 0x00.
- R2: A direct access and an indirect access to an address in 0x00-0x7F reach the same RAM byte.
- R3: A register access (type 00) to register n reaches RAM byte bank_sel*8 + (addr mod 8). The byte lies in 0x00-0x1F.
- R4: A bit access (type 11) with address a below 0x80 reaches RAM byte 0x20 + (a div 8), at bit position a mod 8.
- R5: An indirect access (type 10) to 0x80-0xFF reaches upper RAM. It never raises sfr_rd or sfr_wr.
- R6: A direct access (type 01) to 0x80-0xFF raises sfr_rd (read) or sfr_wr (write) in the request cycle, with sfr_addr equal to the address. It leaves RAM unchanged.
- R7: A bit access with address a of 0x80 or above reaches port register a - (a mod 8), at bit position a mod 8.
- R8: A bit write changes only the selected bit of the target byte. For a port register, the new byte is driven on sfr_wdata with sfr_wr in the cycle after the request.
- R9: A read accepted at a clock edge raises rd_valid for exactly the following cycle. rd_data then holds the addressed byte and rd_bit holds the selected bit (bit accesses).
- R10: An accepted bit write drops ready for exactly one cycle. A request presented in that cycle is ignored: it produces no strobe and no rd_valid.
- R11: The access type encoding is 00 register, 01 direct, 10 indirect, 11 bit. When wr_req and rd_req are both high, the request is a write and no rd_valid follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, taken at a rising edge while ready is high |
| wr_req | input | 1 | Write request, takes precedence over rd_req |
| acc_type | input | 2 | Access kind: 00 register, 01 direct, 10 indirect, 11 bit |
| addr | input | 8 | Register number, byte address or bit address |
| wdata | input | 8 | Byte to write |
| wbit | input | 1 | Bit value for bit writes |
| bank_sel | input | 2 | Working-register bank select |
| ready | output | 1 | High when a request can be taken |
| rd_valid | output | 1 | One-cycle pulse marking read data valid |
| rd_data | output | 8 | Byte returned by a read |
| rd_bit | output | 1 | Selected bit returned by a bit read |
| sfr_addr | output | 8 | Port register address |
| sfr_rd | output | 1 | Port read strobe; data expected on sfr_rdata next cycle |
| sfr_wr | output | 1 | Port write strobe |
| sfr_wdata | output | 8 | Port write data |
| sfr_rdata | input | 8 | Port read data, one cycle after sfr_rd |

## Verification
The assertions check several properties on every cycle. Indirect requests never strobe the port. Direct upper-half writes never write RAM. The read-modify-write cycle writes exactly one store. Upper bit addresses produce port addresses aligned to eight. The stall and the rd_valid pulse fall in the right cycles. The clear sweep ends on the last address. Only the bench scenarios can show data correctness: bank remapping, the bit-to-byte mapping, the preserved neighbouring bits, write-over-read precedence, and the request ignored during a stall. The bench checks these against its own model of both stores.

// File: rtl/idm_pkg.sv
package idm_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int BANK_W  = 2;
  localparam int POS_W   = 3;
  localparam logic [ADDR_W-1:0] BIT_RAM_BASE = 8'h20;

  typedef enum logic [1:0] {
    ACC_REG = 2'b00,
    ACC_DIR = 2'b01,
    ACC_IND = 2'b10,
    ACC_BIT = 2'b11
  } acc_e;

  // working register n in bank b
  function automatic logic [ADDR_W-1:0] reg_byte(input logic [BANK_W-1:0] bank,
                                                  input logic [POS_W-1:0] n);
    return {{(ADDR_W-BANK_W-POS_W){1'b0}}, bank, n};
  endfunction

  // byte holding a given bit address
  function automatic logic [ADDR_W-1:0] bit_byte(input logic [ADDR_W-1:0] ba);
    if (ba[ADDR_W-1])
      return {ba[ADDR_W-1:POS_W], {POS_W{1'b0}}};
    else
      return BIT_RAM_BASE + {{(POS_W+1){1'b0}}, ba[ADDR_W-2:POS_W]};
  endfunction

  function automatic logic [BYTE_W-1:0] put_bit(input logic [BYTE_W-1:0] b,
                                                input logic [POS_W-1:0] p,
                                                input logic v);
    logic [BYTE_W-1:0] r;
    r    = b;
    r[p] = v;
    return r;
  endfunction
endpackage

// File: rtl/idm_decode.sv
module idm_decode
  import idm_pkg::*;
(
  input  logic [1:0]        acc_type,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              to_sfr,
  output logic              is_bit,
  output logic [ADDR_W-1:0] byte_addr,
  output logic [POS_W-1:0]  bit_pos
);
  acc_e kind;
  assign kind = acc_e'(acc_type);

  always_comb begin
    to_sfr    = 1'b0;
    is_bit    = 1'b0;
    byte_addr = addr;
    bit_pos   = addr[POS_W-1:0];
    unique case (kind)
      ACC_REG: byte_addr = reg_byte(bank_sel, addr[POS_W-1:0]);
      ACC_DIR: to_sfr    = addr[ADDR_W-1];
      ACC_IND: to_sfr    = 1'b0;
      ACC_BIT: begin
        is_bit    = 1'b1;
        to_sfr    = addr[ADDR_W-1];
        byte_addr = bit_byte(addr);
      end
      default: to_sfr = 1'b0;
    endcase
  end
endmodule

// File: rtl/idm_ram.sv
module idm_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/idm_seq.sv
module idm_seq
  import idm_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = BYTE_W,
  parameter int PW = POS_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic          wr_req,
  input  logic          is_bit,
  input  logic          to_sfr,
  input  logic [AW-1:0] byte_addr,
  input  logic [PW-1:0] bit_pos,
  input  logic          wbit,
  input  logic [DW-1:0] ram_q,
  input  logic [DW-1:0] sfr_rdata,
  output logic          ready,
  output logic          accept,
  output logic          clearing,
  output logic [AW-1:0] clr_idx,
  output logic          rmw,
  output logic [AW-1:0] ctx_addr,
  output logic          ctx_sfr,
  output logic [DW-1:0] new_byte,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_bit
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  typedef enum logic [1:0] {S_CLEAR, S_RUN, S_RMW} st_e;
  st_e state_q;

  logic [PW-1:0] ctx_pos_q;
  logic          ctx_wbit_q;
  logic          rdv_q;
  logic [DW-1:0] got_byte;
  logic          start_rmw;

  assign ready     = (state_q == S_RUN);
  assign clearing  = (state_q == S_CLEAR);
  assign rmw       = (state_q == S_RMW);
  assign accept    = ready && (rd_req || wr_req);
  assign start_rmw = accept && wr_req && is_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_CLEAR;
      clr_idx    <= '0;
      ctx_addr   <= '0;
      ctx_pos_q  <= '0;
      ctx_sfr    <= 1'b0;
      ctx_wbit_q <= 1'b0;
      rdv_q      <= 1'b0;
    end else begin
      unique case (state_q)
        S_CLEAR: begin
          clr_idx <= clr_idx + 1'b1;
          if (clr_idx == LAST) state_q <= S_RUN;
        end
        S_RUN:   if (start_rmw) state_q <= S_RMW;
        S_RMW:   state_q <= S_RUN;
        default: state_q <= S_CLEAR;
      endcase
      rdv_q <= accept && !wr_req;
      if (accept) begin
        ctx_addr   <= byte_addr;
        ctx_pos_q  <= bit_pos;
        ctx_sfr    <= to_sfr;
        ctx_wbit_q <= wbit;
      end
    end
  end

  assign got_byte = ctx_sfr ? sfr_rdata : ram_q;
  assign new_byte = put_bit(got_byte, ctx_pos_q, ctx_wbit_q);
  assign rd_valid = rdv_q;
  assign rd_data  = got_byte;
  assign rd_bit   = got_byte[ctx_pos_q];

  // R10: a bit write stalls for one cycle, then the unit is open again
  a_r10_stall_starts: assert property (@(posedge clk) disable iff (!rst_n)
    start_rmw |=> !ready);
  a_r10_stall_ends: assert property (@(posedge clk) disable iff (!rst_n)
    rmw |=> ready);
  // R9: rd_valid follows an accepted read by one cycle and only then
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wr_req) |=> rd_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && !wr_req) |=> !rd_valid);
  // R1: the clear sweep ends only after the last address
  a_r1_sweep_complete: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clearing) |-> ($past(clr_idx) == LAST));
endmodule

// File: rtl/idm_unit.sv
module idm_unit
  import idm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic        wr_req,
  input  logic [1:0]  acc_type,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wbit,
  input  logic [1:0]  bank_sel,
  output logic        ready,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        rd_bit,
  output logic [7:0]  sfr_addr,
  output logic        sfr_rd,
  output logic        sfr_wr,
  output logic [7:0]  sfr_wdata,
  input  logic [7:0]  sfr_rdata
);
  logic              to_sfr, is_bit;
  logic [ADDR_W-1:0] byte_addr;
  logic [POS_W-1:0]  bit_pos;
  logic              accept, clearing, rmw, ctx_sfr;
  logic [ADDR_W-1:0] clr_idx, ctx_addr;
  logic [BYTE_W-1:0] new_byte, ram_q;
  logic              ram_we, byte_wr;
  logic [ADDR_W-1:0] ram_waddr;
  logic [BYTE_W-1:0] ram_wdata;

  idm_decode u_dec (
    .acc_type (acc_type),
    .addr     (addr),
    .bank_sel (bank_sel),
    .to_sfr   (to_sfr),
    .is_bit   (is_bit),
    .byte_addr(byte_addr),
    .bit_pos  (bit_pos)
  );

  idm_seq #(.AW(ADDR_W), .DW(BYTE_W), .PW(POS_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .is_bit   (is_bit),
    .to_sfr   (to_sfr),
    .byte_addr(byte_addr),
    .bit_pos  (bit_pos),
    .wbit     (wbit),
    .ram_q    (ram_q),
    .sfr_rdata(sfr_rdata),
    .ready    (ready),
    .accept   (accept),
    .clearing (clearing),
    .clr_idx  (clr_idx),
    .rmw      (rmw),
    .ctx_addr (ctx_addr),
    .ctx_sfr  (ctx_sfr),
    .new_byte (new_byte),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_bit   (rd_bit)
  );

  assign byte_wr   = accept && wr_req && !is_bit;
  assign ram_we    = clearing || (byte_wr && !to_sfr) || (rmw && !ctx_sfr);
  assign ram_waddr = clearing ? clr_idx : (rmw ? ctx_addr : byte_addr);
  assign ram_wdata = clearing ? '0 : (rmw ? new_byte : wdata);

  idm_ram #(.AW(ADDR_W), .DW(BYTE_W)) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .re   (accept),
    .raddr(byte_addr),
    .q    (ram_q)
  );

  assign sfr_rd    = accept && to_sfr && (!wr_req || is_bit);
  assign sfr_wr    = (byte_wr && to_sfr) || (rmw && ctx_sfr);
  assign sfr_addr  = rmw ? ctx_addr : byte_addr;
  assign sfr_wdata = rmw ? new_byte : wdata;

  // R5: indirect requests never touch the port
  a_r5_indirect_no_port: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && acc_type == ACC_IND) |-> (!sfr_rd && !sfr_wr));
  // R6: direct upper-half writes never write RAM
  a_r6_direct_upper_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_req && acc_type == ACC_DIR && addr[7]) |-> !ram_we);
  // R7: upper bit addresses reach an eight-aligned port register
  a_r7_bit_port_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && acc_type == ACC_BIT && addr[7]) |-> (sfr_rd && sfr_addr[2:0] == 3'b000));
  // R8: the write-back cycle writes exactly one store
  a_r8_one_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    rmw |-> ($countones({ram_we, sfr_wr}) == 1));
  // R3: register writes stay in the bank area
  a_r3_reg_in_banks: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_req && acc_type == ACC_REG) |-> (ram_we && ram_waddr[7:5] == 3'b000));
endmodule

// File: tb/idm_unit_test.sv
`timescale 1ns/1ps
module idm_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_req = 1'b0, wr_req = 1'b0, wbit = 1'b0;
  logic [1:0] acc_type = 2'b00, bank_sel = 2'b00;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic       ready, rd_valid, rd_bit, sfr_rd, sfr_wr;
  logic [7:0] rd_data, sfr_addr, sfr_wdata;
  logic [7:0] sfr_rdata = 8'h00;

  logic [7:0] sfr_mem [256];
  logic [7:0] ram_ref [256];
  logic [7:0] sfr_ref [256];
  int checks = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  idm_unit uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .acc_type(acc_type), .addr(addr), .wdata(wdata), .wbit(wbit),
    .bank_sel(bank_sel), .ready(ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_bit(rd_bit), .sfr_addr(sfr_addr),
    .sfr_rd(sfr_rd), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata)
  );

  // register-port slave: one cycle read latency
  always @(posedge clk) begin
    if (sfr_wr) sfr_mem[sfr_addr] <= sfr_wdata;
    if (sfr_rd) sfr_rdata <= sfr_mem[sfr_addr];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected<150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit goes_port(input logic [1:0] t, input logic [7:0] a);
    return (t == 2'd1 || t == 2'd3) && (a >= 8'd128);
  endfunction

  function automatic int loc(input logic [1:0] t, input logic [7:0] a, input logic [1:0] bk);
    int v;
    v = a;
    if (t == 2'd0) return bk * 8 + (v % 8);
    if (t == 2'd3) return (v < 128) ? 32 + v / 8 : v - (v % 8);
    return v;
  endfunction

  function automatic string tag_of(input logic [1:0] t, input logic [7:0] a);
    if (t == 2'd0) return "R3";
    if (t == 2'd3) return (a >= 8'd128) ? "R7" : "R4";
    if (t == 2'd2) return (a >= 8'd128) ? "R5" : "R2";
    return (a >= 8'd128) ? "R6" : "R2";
  endfunction

  task automatic op(input bit rd, input bit wr, input logic [1:0] t, input logic [7:0] a,
                    input logic [7:0] wd, input bit wb, input logic [1:0] bk);
    int    b, p;
    bit    port;
    logic [7:0] old, nb;
    string tg;
    while (!ready) @(negedge clk);
    b = loc(t, a, bk); p = a % 8; port = goes_port(t, a); tg = tag_of(t, a);
    rd_req = rd; wr_req = wr; acc_type = t; addr = a; wdata = wd; wbit = wb; bank_sel = bk;
    #0.5;
    chk(sfr_rd == (port && (!wr || t == 2'd3)), {tg, " sfr_rd"}, sfr_rd, port);
    chk(sfr_wr == (port && wr && t != 2'd3), {tg, " sfr_wr"}, sfr_wr, port && wr);
    if (port) chk(sfr_addr == b[7:0], {tg, " sfr_addr"}, sfr_addr, b);
    @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b0;
    old = port ? sfr_ref[b] : ram_ref[b];
    if (!wr) begin
      if (rd) begin
        chk(rd_valid === 1'b1, "R9 rd_valid", rd_valid, 1);
        chk(rd_data === old, {tg, " rd_data"}, rd_data, old);
        if (t == 2'd3) chk(rd_bit === old[p], {tg, " rd_bit"}, rd_bit, old[p]);
      end
    end else begin
      chk(rd_valid == 1'b0, "R11 no rd_valid on write", rd_valid, 0);
      if (t == 2'd3) begin
        nb = old; nb[p] = wb;
        chk(ready == 1'b0, "R10 stall", ready, 0);
        if (port) begin
          chk(sfr_wr && sfr_addr == b[7:0] && sfr_wdata == nb, "R8 port write-back",
              sfr_wdata, nb);
          sfr_ref[b] = nb;
        end else ram_ref[b] = nb;
        @(negedge clk);
      end else if (port) sfr_ref[b] = wd;
      else ram_ref[b] = wd;
    end
  endtask

  initial begin
    int n;
    bit bad;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      sfr_mem[i] = 8'(i * 7 + 3);
      sfr_ref[i] = 8'(i * 7 + 3);
      ram_ref[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R1 ready low in reset", ready, 0);
    rst_n = 1'b1;
    n = 0;
    while (!ready) begin @(negedge clk); n++; end
    chk(n == 256, "R1 clear length", n, 256);

    bad = 0;
    for (int i = 0; i < 256; i++) begin
      while (!ready) @(negedge clk);
      rd_req = 1'b1; acc_type = 2'd2; addr = 8'(i);
      @(negedge clk);
      rd_req = 1'b0;
      if (rd_data !== 8'h00 || rd_valid !== 1'b1) bad = 1;
    end
    chk(!bad, "R1 all bytes zero", bad, 0);

    // directed corner cases
    op(0, 1, 2'd1, 8'h40, 8'h5A, 0, 2'd0);   // R2 direct write
    op(1, 0, 2'd2, 8'h40, 8'h00, 0, 2'd0);   // R2 indirect read back
    op(0, 1, 2'd0, 8'h05, 8'hA5, 0, 2'd2);   // R3 bank 2, register 5
    op(1, 0, 2'd1, 8'h15, 8'h00, 0, 2'd0);   // R3 seen at 0x15
    op(0, 1, 2'd0, 8'h07, 8'h3C, 0, 2'd3);   // R3 last register of bank 3
    op(1, 0, 2'd1, 8'h1F, 8'h00, 0, 2'd1);
    op(0, 1, 2'd1, 8'h2F, 8'h55, 0, 2'd0);
    op(0, 1, 2'd3, 8'h7F, 8'h00, 1, 2'd0);   // R4 top bit of 0x2F
    op(1, 0, 2'd1, 8'h2F, 8'h00, 0, 2'd0);   // R8 neighbours kept: 0xD5
    op(0, 1, 2'd3, 8'h00, 8'h00, 1, 2'd0);   // R4 bit 0 of 0x20
    op(1, 0, 2'd3, 8'h00, 8'h00, 0, 2'd0);
    op(0, 1, 2'd2, 8'h90, 8'hC3, 0, 2'd0);   // R5 upper RAM
    op(0, 1, 2'd1, 8'h90, 8'h11, 0, 2'd0);   // R6 port, RAM kept
    op(1, 0, 2'd2, 8'h90, 8'h00, 0, 2'd0);   // R5 still 0xC3
    op(1, 0, 2'd1, 8'h90, 8'h00, 0, 2'd0);   // R6 port byte 0x11
    op(0, 1, 2'd3, 8'h87, 8'h00, 0, 2'd0);   // R7 bit 7 of port 0x80
    op(0, 1, 2'd3, 8'hFF, 8'h00, 1, 2'd0);   // R7 bit 7 of port 0xF8
    op(1, 0, 2'd3, 8'hFF, 8'h00, 0, 2'd0);
    op(1, 1, 2'd1, 8'h33, 8'h77, 0, 2'd0);   // R11 write wins
    op(1, 0, 2'd1, 8'h33, 8'h00, 0, 2'd0);

    // R10: a request inside the stall cycle is ignored
    while (!ready) @(negedge clk);
    wr_req = 1'b1; acc_type = 2'd3; addr = 8'h08; wbit = 1'b1;
    @(negedge clk);
    ram_ref[33][0] = 1'b1;
    wr_req = 1'b0; rd_req = 1'b1; acc_type = 2'd1; addr = 8'hA0;
    #0.5;
    chk(ready == 1'b0 && sfr_rd == 1'b0, "R10 ignored in stall", sfr_rd, 0);
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_valid == 1'b0, "R10 no rd_valid after stall", rd_valid, 0);
    op(1, 0, 2'd1, 8'h21, 8'h00, 0, 2'd0);

    // constrained random mix
    for (int k = 0; k < 1500; k++) begin
      logic [1:0] t;
      bit w;
      t = 2'($urandom % 4);
      w = ($urandom % 2) == 0;
      op(!w || ($urandom % 4 == 0), w, t, 8'($urandom), 8'($urandom),
         1'($urandom), 2'($urandom));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule